// File: doc/BRIEF.md
# Single-Wire RGB LED Strip Encoder

This block turns a stream of colour pixels into the one-pin pulse-width waveform that chains of addressable RGB LEDs decode. Each pixel arrives as separate red, green and blue bytes on a valid/ready stream. The block reorders it for the wire as green, red, blue. It sends every bit as a high pulse whose length encodes the bit value, followed by a fixed low time. All durations are whole cycles of a 16 MHz clock.

A one-pixel holding register sits in front of the serializer. While one pixel is on the wire, the next one can be accepted, so bits run back to back without a stall that the strip could take for a latch. A static configuration input selects three-byte pixels or four-byte pixels. In the four-byte format, the fourth byte is a white slot that is always sent as zero. A frame-end pulse asks the block to close the frame. Once the accepted pixels have run out, the line rests low for a configurable latch interval, and busy stays high during that interval. If the pixels run out before frame-end has been requested, this is recorded on a sticky underrun flag, which software clears with a pulse.

Top module: `ledstrip_encoder`

## Requirements
- R1: A bit of value 1 drives `line_out` high for exactly T1H_CYC cycles (default 12).
- R2: A bit of value 0 drives `line_out` high for exactly T0H_CYC cycles (default 4).
- R3: Within a frame, every high pulse is followed by exactly TLOW_CYC low cycles (default 8) before the next pulse. This holds between pixels as well as inside one, as long as the next pixel was accepted in time.
- R4: Each pixel goes out as the green byte, then the red byte, then the blue byte, each most significant bit first, whatever the input port order.
- R5: With `cfg_white` = 0 a pixel is 24 bits long. With `cfg_white` = 1 it is 32 bits, and the last 8 are all zero. `cfg_white` is sampled when a pixel starts.
- R6: A `frame_end` pulse closes the frame at the first pixel boundary where no pixel is waiting. The last bit's low time is followed by RESET_CYC further low cycles (default 800), with `busy` high throughout. `busy` therefore falls exactly TLOW_CYC + RESET_CYC cycles after the last falling edge of `line_out`.
- R7: `in_ready` is high exactly when the holding register is empty. A pixel is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle after an acceptance.
- R8: If a pixel finishes with no pixel waiting and no frame-end pending, `underrun` goes to 1 and the line stays low. `underrun` stays 1 until `underrun_clr` is pulsed, and a new underrun in the same cycle as a clear wins.
- R9: After synchronous active-high reset, `line_out` is 0, `busy` is 0, `underrun` is 0 and `in_ready` is 1. `line_out` is never high while `busy` is low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz bit-timing clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_white | input | 1 | 1 selects four-byte pixels with a zero white slot |
| in_valid | input | 1 | Pixel stream valid |
| in_red | input | 8 | Red byte |
| in_green | input | 8 | Green byte |
| in_blue | input | 8 | Blue byte |
| in_ready | output | 1 | Holding register empty, pixel can be taken |
| frame_end | input | 1 | One-cycle request to close the frame |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| line_out | output | 1 | Serial data line to the strip |
| busy | output | 1 | Pixel pending, bit on the wire, or latch interval running |
| underrun | output | 1 | Sticky flag: stream ran dry inside a frame |

## Verification
The bench keeps the pulse parameters at their defaults of 4, 12 and 8 cycles, so every high and low width it measures is the production value. It builds the block with RESET_CYC set to 40 instead of 800. That makes the latch interval short enough to run many frames, while the bench still counts it to the exact cycle. Frames mix three-byte and four-byte pixels, all-zero and all-one bytes, and an asymmetric colour pattern that exposes byte or bit order mistakes. A deliberately starved pixel exercises the sticky underrun flag.

// File: rtl/ledenc_pkg.sv
package ledenc_pkg;

  localparam int unsigned CHAN_W = 8;
  localparam int unsigned WORD_W = 4 * CHAN_W;

  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] green;
    logic [CHAN_W-1:0] blue;
  } rgb_t;

  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW, PH_GAP} phase_e;

  // Wire order: green, red, blue, then a zero slot used only in four-byte mode
  function automatic logic [WORD_W-1:0] wire_word(rgb_t p);
    return {p.green, p.red, p.blue, {CHAN_W{1'b0}}};
  endfunction

  function automatic int unsigned symbol_bits(logic white);
    return white ? 4 * CHAN_W : 3 * CHAN_W;
  endfunction

  function automatic int unsigned high_cycles(logic b, int unsigned t0, int unsigned t1);
    return b ? t1 : t0;
  endfunction

endpackage

// File: rtl/ledenc_holdreg.sv
module ledenc_holdreg
  import ledenc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  rgb_t in_pix,
  output logic in_ready,
  input  logic take,
  output logic pix_valid,
  output rgb_t pix
);

  logic full_q;
  rgb_t data_q;

  assign in_ready  = !full_q;
  assign pix_valid = full_q;
  assign pix       = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_pix;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  // A waiting pixel is neither lost nor altered until the serializer takes it
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !take) |=> (pix_valid && $stable(pix)));

endmodule

// File: rtl/ledenc_serializer.sv
module ledenc_serializer
  import ledenc_pkg::*;
#(
  parameter int unsigned T0H_CYC   = 4,
  parameter int unsigned T1H_CYC   = 12,
  parameter int unsigned TLOW_CYC  = 8,
  parameter int unsigned RESET_CYC = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_white,
  input  logic pix_valid,
  input  rgb_t pix,
  output logic take,
  input  logic end_req,
  output logic line_out,
  output logic active,
  output logic starve
);

  localparam int unsigned MAX_A = (T1H_CYC > TLOW_CYC) ? T1H_CYC : TLOW_CYC;
  localparam int unsigned MAX_B = (MAX_A > T0H_CYC) ? MAX_A : T0H_CYC;
  localparam int unsigned MAXC  = (MAX_B > RESET_CYC) ? MAX_B : RESET_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam int unsigned BL_W  = $clog2(WORD_W + 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BL_W-1:0]   bits_left_q;
  logic              end_pend_q;

  logic              bit_done;
  logic              pix_done;
  logic              boundary;
  logic              load;
  logic              start_gap;
  logic [WORD_W-1:0] next_word;

  assign next_word = wire_word(pix);
  assign bit_done  = (phase_q == PH_LOW) && (cnt_q == '0);
  assign pix_done  = bit_done && (bits_left_q == BL_W'(1));
  assign boundary  = (phase_q == PH_IDLE) || pix_done;
  assign load      = boundary && pix_valid;
  assign start_gap = boundary && !pix_valid && end_pend_q;
  assign starve    = pix_done && !pix_valid && !end_pend_q;
  assign take      = load;
  assign line_out  = (phase_q == PH_HIGH);
  assign active    = (phase_q != PH_IDLE) || end_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      end_pend_q <= 1'b0;
    end else if (start_gap) begin
      end_pend_q <= end_req;
    end else if (end_req) begin
      end_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      shreg_q     <= '0;
      bits_left_q <= '0;
    end else if (load) begin
      phase_q     <= PH_HIGH;
      cnt_q       <= CNT_W'(high_cycles(next_word[WORD_W-1], T0H_CYC, T1H_CYC) - 1);
      shreg_q     <= next_word;
      bits_left_q <= BL_W'(symbol_bits(cfg_white));
    end else if (start_gap) begin
      phase_q <= PH_GAP;
      cnt_q   <= CNT_W'(RESET_CYC - 1);
    end else begin
      unique case (phase_q)
        PH_HIGH: begin
          if (cnt_q == '0) begin
            phase_q <= PH_LOW;
            cnt_q   <= CNT_W'(TLOW_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (bits_left_q > BL_W'(1)) begin
            phase_q     <= PH_HIGH;
            cnt_q       <= CNT_W'(high_cycles(shreg_q[WORD_W-2], T0H_CYC, T1H_CYC) - 1);
            shreg_q     <= shreg_q << 1;
            bits_left_q <= bits_left_q - 1'b1;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        PH_GAP: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Run-length observers of the line, used only by the properties below
  logic [CNT_W-1:0] hi_run_q;
  logic [CNT_W-1:0] lo_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run_q <= '0;
      lo_run_q <= CNT_W'(TLOW_CYC);
    end else if (line_out) begin
      hi_run_q <= hi_run_q + 1'b1;
      lo_run_q <= '0;
    end else begin
      hi_run_q <= '0;
      if (lo_run_q < CNT_W'(TLOW_CYC)) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  // R1 and R2: every pulse is exactly one of the two symbol widths
  assert_high_width_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(line_out) |-> (hi_run_q == CNT_W'(T1H_CYC) || hi_run_q == CNT_W'(T0H_CYC)));

  // R3: no pulse starts before the low time of the previous one has elapsed
  assert_low_time_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(line_out) |-> (lo_run_q == CNT_W'(TLOW_CYC)));

endmodule

// File: rtl/ledstrip_encoder.sv
module ledstrip_encoder
  import ledenc_pkg::*;
#(
  parameter int unsigned T0H_CYC   = 4,
  parameter int unsigned T1H_CYC   = 12,
  parameter int unsigned TLOW_CYC  = 8,
  parameter int unsigned RESET_CYC = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_white,
  input  logic              in_valid,
  input  logic [CHAN_W-1:0] in_red,
  input  logic [CHAN_W-1:0] in_green,
  input  logic [CHAN_W-1:0] in_blue,
  output logic              in_ready,
  input  logic              frame_end,
  input  logic              underrun_clr,
  output logic              line_out,
  output logic              busy,
  output logic              underrun
);

  rgb_t in_pix;
  rgb_t held_pix;
  logic held_valid;
  logic take;
  logic ser_active;
  logic starve;
  logic underrun_q;

  assign in_pix = '{red: in_red, green: in_green, blue: in_blue};

  ledenc_holdreg u_hold (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .in_ready  (in_ready),
    .take      (take),
    .pix_valid (held_valid),
    .pix       (held_pix)
  );

  ledenc_serializer #(
    .T0H_CYC   (T0H_CYC),
    .T1H_CYC   (T1H_CYC),
    .TLOW_CYC  (TLOW_CYC),
    .RESET_CYC (RESET_CYC)
  ) u_ser (
    .clk       (clk),
    .rst       (rst),
    .cfg_white (cfg_white),
    .pix_valid (held_valid),
    .pix       (held_pix),
    .take      (take),
    .end_req   (frame_end),
    .line_out  (line_out),
    .active    (ser_active),
    .starve    (starve)
  );

  always_ff @(posedge clk) begin
    if (rst)               underrun_q <= 1'b0;
    else if (starve)       underrun_q <= 1'b1;
    else if (underrun_clr) underrun_q <= 1'b0;
  end

  assign underrun = underrun_q;
  assign busy     = ser_active || held_valid;

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

endmodule

// File: tb/tb_ledstrip_encoder.sv
module tb_ledstrip_encoder;

  localparam int T0H = 4;
  localparam int T1H = 12;
  localparam int TLO = 8;
  localparam int RST_GAP = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_white = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_red = '0, in_green = '0, in_blue = '0;
  logic in_ready;
  logic frame_end = 1'b0;
  logic underrun_clr = 1'b0;
  logic line_out, busy, underrun;

  always #4 clk = ~clk;

  ledstrip_encoder #(.T0H_CYC(T0H), .T1H_CYC(T1H), .TLOW_CYC(TLO), .RESET_CYC(RST_GAP)) dut (
    .clk(clk), .rst(rst), .cfg_white(cfg_white), .in_valid(in_valid),
    .in_red(in_red), .in_green(in_green), .in_blue(in_blue), .in_ready(in_ready),
    .frame_end(frame_end), .underrun_clr(underrun_clr),
    .line_out(line_out), .busy(busy), .underrun(underrun));

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // Line monitor: sampled on the falling clock edge
  int his[$];
  int lows[$];
  bit prev_line = 0, prev_busy = 0, seen_fall = 0;
  int hi_cnt = 0, lo_cnt = 0, since_fall = 0, last_gap = -1;

  always @(negedge clk) begin
    if (rst) begin
      prev_line = 0; prev_busy = 0; hi_cnt = 0; lo_cnt = 0;
    end else begin
      if (line_out) begin
        if (!prev_line && seen_fall) lows.push_back(lo_cnt);
        hi_cnt++;
      end else begin
        if (prev_line) begin
          his.push_back(hi_cnt);
          hi_cnt = 0; seen_fall = 1; lo_cnt = 0; since_fall = 0;
        end
        lo_cnt++;
        if (busy) since_fall++;
      end
      if (prev_busy && !busy) last_gap = since_fall;
      prev_line = line_out;
      prev_busy = busy;
    end
  end

  bit exp_bits[$];

  function automatic void add_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_bits.push_back(b[i]);
  endfunction

  // Expected wire image of one pixel, built from the requirements (R4, R5)
  function automatic void add_pixel(input logic [7:0] r, input logic [7:0] g,
                                    input logic [7:0] b, input bit white);
    add_byte(g); add_byte(r); add_byte(b);
    if (white) add_byte(8'h00);
  endfunction

  task automatic push(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_red = r; in_green = g; in_blue = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R7", "ready after accept", int'(in_ready), 0);
    add_pixel(r, g, b, cfg_white);
  endtask

  task automatic pulse_end();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic clear_mon();
    @(posedge clk);
    his.delete(); lows.delete(); exp_bits.delete();
    seen_fall = 0; last_gap = -1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_wire(input bit check_gap);
    int ones_exp = 0, zeros_exp = 0, ones_seen = 0, zeros_seen = 0, bad_low = 0, mism = 0;
    check(his.size() == exp_bits.size(), "R5", "bit count", his.size(), exp_bits.size());
    foreach (exp_bits[i]) begin
      if (exp_bits[i]) ones_exp++; else zeros_exp++;
      if (i < his.size()) begin
        if (his[i] == T1H) ones_seen++;
        if (his[i] == T0H) zeros_seen++;
        if ((his[i] == T1H) != exp_bits[i]) mism++;
      end
    end
    check(ones_seen == ones_exp, "R1", "12-cycle pulses", ones_seen, ones_exp);
    check(zeros_seen == zeros_exp, "R2", "4-cycle pulses", zeros_seen, zeros_exp);
    check(mism == 0, "R4", "bits out of order", mism, 0);
    foreach (lows[i]) if (lows[i] != TLO) bad_low++;
    check(bad_low == 0, "R3", "inter-bit low widths", bad_low, 0);
    if (check_gap) check(last_gap == TLO + RST_GAP, "R6", "busy tail after last fall",
                         last_gap, TLO + RST_GAP);
  endtask

  function automatic logic [7:0] pick(input int mode);
    case (mode)
      1: return 8'h00;
      2: return 8'hFF;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic run_frame(input int npix, input bit white, input int mode);
    clear_mon();
    @(negedge clk); cfg_white = white;
    for (int p = 0; p < npix; p++) begin
      if (mode == 3) push(8'h01, 8'h80, 8'h3C);
      else push(pick(mode), pick(mode), pick(mode));
      repeat ($urandom_range(0, 30)) @(negedge clk);
    end
    pulse_end();
    wait_idle();
    check_wire(1'b1);
    check(in_ready == 1'b1, "R7", "ready when idle", int'(in_ready), 1);
    check(underrun == 1'b0, "R8", "no underrun in fed frame", int'(underrun), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check(line_out == 1'b0, "R9", "line in reset", int'(line_out), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(line_out == 1'b0 && busy == 1'b0, "R9", "line|busy after reset",
          int'({line_out, busy}), 0);
    check(underrun == 1'b0, "R9", "underrun after reset", int'(underrun), 0);
    check(in_ready == 1'b1, "R9", "ready after reset", int'(in_ready), 1);

    run_frame(3, 1'b0, 3);   // asymmetric colours expose byte and bit order
    run_frame(2, 1'b0, 1);   // all-zero bits
    run_frame(2, 1'b0, 2);   // all-one bits
    run_frame(2, 1'b1, 3);   // four-byte pixels with zero white slot
    for (int f = 0; f < 6; f++)
      run_frame(int'($urandom_range(1, 6)), 1'($urandom_range(0, 1)), 0);

    // Underrun: one pixel and no frame-end
    clear_mon();
    @(negedge clk); cfg_white = 1'b0;
    push(8'hA5, 8'h5A, 8'hC3);
    wait_idle();
    check_wire(1'b0);
    check(underrun == 1'b1, "R8", "underrun set", int'(underrun), 1);
    check(line_out == 1'b0, "R8", "line low after starve", int'(line_out), 0);
    repeat (50) @(negedge clk);
    check(underrun == 1'b1, "R8", "underrun sticky", int'(underrun), 1);
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    check(underrun == 1'b0, "R8", "underrun cleared", int'(underrun), 0);

    run_frame(2, 1'b1, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule